// File: doc/BRIEF.md
# I2C Multi-Master Arbitration and Collision Guard

This block sits between a local I2C master engine (bit sequencer, byte shifter, clock generator) and the open-drain SDA/SCL lines. It synchronizes both bus lines and compares every level the local master intends to leave on SDA with the level seen while SCL is high. When the master has released SDA (intends a 1) but the line reads 0, another master has won arbitration. The guard then abandons the operation in progress, whether a Start, Restart, Stop, Acknowledge or data byte. It forces both lines released, drops every pending sequence request and the transmit-full flag, latches a sticky arbitration-lost flag and pulses the master interrupt once.

After a loss the guard keeps monitoring the bus. The next Stop condition pulses the master interrupt a second time, so software learns when it may retry. Independently of arbitration it detects Start and Stop conditions, pulses an event interrupt for each, and keeps two status bits from which bus-free is derived. A sleep input aborts any transfer. An idle input does the same, but only when the stop-in-idle control bit is set. A transmit-register write reloads a bit pointer, so a retried byte always begins at its most significant bit.

Top module: `i2c_arb_guard`

## Requirements
- R1: While an operation is pending (any request bit set or transmit-full set), SDA and the delayed intent both synchronized, if SDA reads 0 while SCL is high and the master's intent is released (1), `arb_lost` sets and `mst_irq` pulses for exactly one cycle.
- R2: On an arbitration loss `tx_full` clears, and `sda_out` and `scl_out` read 1 whatever the master drives, until the next `tx_write` or a nonzero `req_set`.
- R3: On an arbitration loss every pending request bit clears to 0. Bit 0 is Start, bit 1 Restart, bit 2 Stop, bit 3 Acknowledge.
- R4: After a loss, the next Stop condition pulses `mst_irq` once more. A Stop with no preceding loss gives no `mst_irq`.
- R5: `tx_write` sets `tx_full`, clears `arb_lost` and loads `bit_ptr` with DATA_BITS (8). Each synchronized SCL falling edge while `tx_full` is set lowers it by one, saturating at 0, so during a byte it equals the index of the bit on the bus.
- R6: A Start is SDA falling while SCL is high; a Stop is SDA rising while SCL is high. Each pulses `evt_irq` once. Start sets `start_seen` and clears `stop_seen`; Stop does the reverse.
- R7: `bus_free` is 1 when `stop_seen` is set or when `start_seen` and `stop_seen` are both clear.
- R8: `sleep_req` clears all request bits and `tx_full` and releases both lines, without pulsing `mst_irq`.
- R9: `idle_req` acts as `sleep_req` when `stop_in_idle` is 1, and has no effect on requests, `tx_full` or the lines when it is 0.
- R10: A master whose released bits are never pulled low keeps `arb_lost` at 0, keeps `tx_full`, raises no `mst_irq`, and its line outputs follow its own drive.
- R11: After reset, requests, `tx_full`, `arb_lost`, `start_seen`, `stop_seen` and `bit_ptr` are 0, `bus_free` is 1, and the line outputs follow the master's drive.
- R12: With no request and no transmit pending, SDA pulled low by another master raises no arbitration loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled SCL bus level |
| sda_in | input | 1 | Sampled SDA bus level |
| mst_scl_rel | input | 1 | Master engine SCL output, 1 = released |
| mst_sda_rel | input | 1 | Master engine SDA output, 1 = released |
| req_set | input | NREQ | Pulses that raise sequence requests (0 Start, 1 Restart, 2 Stop, 3 Ack) |
| req_done | input | NREQ | Pulses from the sequencer that retire requests |
| tx_write | input | 1 | Transmit register written |
| tx_done | input | 1 | Byte shifter finished the byte |
| sleep_req | input | 1 | Low-power sleep, aborts activity |
| idle_req | input | 1 | Low-power idle |
| stop_in_idle | input | 1 | 1 = idle halts the block |
| scl_out | output | 1 | SCL to pad, 1 = released |
| sda_out | output | 1 | SDA to pad, 1 = released |
| req_pend | output | NREQ | Pending sequence requests |
| tx_full | output | 1 | Transmit-buffer-full flag |
| bit_ptr | output | PTR_W | Index of the data bit on the bus |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| start_seen | output | 1 | Last condition seen was a Start |
| stop_seen | output | 1 | Last condition seen was a Stop |
| bus_free | output | 1 | Bus may be claimed |
| mst_irq | output | 1 | Master interrupt pulse |
| evt_irq | output | 1 | Start/Stop event interrupt pulse |

## Verification
Two guards share a wired-AND bus and send byte pairs that differ in each single bit position, plus an identical pair. The bench predicts the winner as the lower value and the bus byte as their minimum. A guard that compared unaligned intent, or flagged a driven 0, would make both lose or neither. The loser's pointer must stop at the bit where it lost and reload to 8 on the next write: a design that kept the old pointer would resume mid-byte. A Start collision with Start and Ack pending checks that requests clear and that the following Stop re-raises the master interrupt. Sleep, idle with and without stop-in-idle, and an idle guard watching another master catch designs that abort when they should not, or fail to.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

    localparam int REQ_START   = 0;
    localparam int REQ_RESTART = 1;
    localparam int REQ_STOP    = 2;
    localparam int REQ_ACK     = 3;

    function automatic logic bus_free_f(input logic start_seen, input logic stop_seen);
        return stop_seen | (~start_seen & ~stop_seen);
    endfunction

endpackage

// File: rtl/i2c_arb_sync.sv
module i2c_arb_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (STAGES == 1) begin : g_one
            logic st_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= 1'b1;
                else        st_q <= d_in[b];
            end
            assign d_out[b] = st_q;
        end else begin : g_many
            logic [STAGES-1:0] st_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '1;
                else        st_q <= {st_q[STAGES-2:0], d_in[b]};
            end
            assign d_out[b] = st_q[STAGES-1];
        end
    end

endmodule

// File: rtl/i2c_arb_cond.sv
module i2c_arb_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_high,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic scl_p;
        logic sda_p;
    } cond_t;

    cond_t cur_q, cur_d;

    always_comb begin
        cur_d       = cur_q;
        cur_d.scl_p = scl_s;
        cur_d.sda_p = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{scl_p: 1'b1, sda_p: 1'b1};
        else        cur_q <= cur_d;
    end

    assign scl_high  = scl_s & cur_q.scl_p;
    assign scl_fall  = cur_q.scl_p & ~scl_s;
    assign start_det = scl_high & cur_q.sda_p & ~sda_s;
    assign stop_det  = scl_high & ~cur_q.sda_p & sda_s;

    AST_START_NEEDS_HIGH_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> $past(scl_s) && $past(!sda_s)); // R6

endmodule

// File: rtl/i2c_arb_core.sv
module i2c_arb_core
    import i2c_arb_pkg::*;
#(
    parameter int NREQ      = 4,
    parameter int DATA_BITS = 8,
    localparam int PW       = $clog2(DATA_BITS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_high,
    input  logic            scl_fall,
    input  logic            sda_s,
    input  logic            rel_s,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic [NREQ-1:0] req_set,
    input  logic [NREQ-1:0] req_done,
    input  logic            tx_write,
    input  logic            tx_done,
    input  logic            sleep_req,
    input  logic            idle_req,
    input  logic            stop_in_idle,
    output logic            release_o,
    output logic [NREQ-1:0] req_o,
    output logic            tx_full_o,
    output logic [PW-1:0]   ptr_o,
    output logic            lost_o,
    output logic            start_seen_o,
    output logic            stop_seen_o,
    output logic            bus_free_o,
    output logic            mst_irq_o,
    output logic            evt_irq_o
);

    typedef struct packed {
        logic [NREQ-1:0] req;
        logic            tx_full;
        logic [PW-1:0]   ptr;
        logic            released;
        logic            await_stop;
        logic            lost;
        logic            start_seen;
        logic            stop_seen;
        logic            mst_irq;
        logic            evt_irq;
    } core_t;

    localparam logic [PW-1:0] PTR_LOAD = PW'(DATA_BITS);

    core_t st_q, st_d;
    logic  halt;
    logic  pending;
    logic  coll;

    assign halt    = sleep_req | (idle_req & stop_in_idle);
    assign pending = (|st_q.req) | st_q.tx_full;
    assign coll    = ~halt & pending & scl_high & rel_s & ~sda_s;

    always_comb begin
        st_d         = st_q;
        st_d.mst_irq = 1'b0;
        st_d.evt_irq = 1'b0;
        if (halt) begin
            st_d.req      = '0;
            st_d.tx_full  = 1'b0;
            st_d.released = 1'b1;
        end else begin
            if (start_det) begin
                st_d.start_seen = 1'b1;
                st_d.stop_seen  = 1'b0;
                st_d.evt_irq    = 1'b1;
            end
            if (stop_det) begin
                st_d.start_seen = 1'b0;
                st_d.stop_seen  = 1'b1;
                st_d.evt_irq    = 1'b1;
                if (st_q.await_stop) begin
                    st_d.mst_irq    = 1'b1;
                    st_d.await_stop = 1'b0;
                end
            end
            if (scl_fall && st_q.tx_full && st_q.ptr != '0) begin
                st_d.ptr = st_q.ptr - 1'b1;
            end
            st_d.req = (st_q.req & ~req_done) | req_set;
            if (|req_set) begin
                st_d.released = 1'b0;
            end
            if (tx_done) begin
                st_d.tx_full = 1'b0;
            end
            if (tx_write) begin
                st_d.tx_full  = 1'b1;
                st_d.ptr      = PTR_LOAD;
                st_d.released = 1'b0;
                st_d.lost     = 1'b0;
            end
            if (coll) begin
                st_d.req        = '0;
                st_d.tx_full    = 1'b0;
                st_d.released   = 1'b1;
                st_d.lost       = 1'b1;
                st_d.await_stop = 1'b1;
                st_d.mst_irq    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign release_o    = st_q.released;
    assign req_o        = st_q.req;
    assign tx_full_o    = st_q.tx_full;
    assign ptr_o        = st_q.ptr;
    assign lost_o       = st_q.lost;
    assign start_seen_o = st_q.start_seen;
    assign stop_seen_o  = st_q.stop_seen;
    assign bus_free_o   = bus_free_f(st_q.start_seen, st_q.stop_seen);
    assign mst_irq_o    = st_q.mst_irq;
    assign evt_irq_o    = st_q.evt_irq;

    AST_COLL_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        coll |=> st_q.req == '0 && !st_q.tx_full && st_q.released && st_q.lost); // R2

    AST_HALT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> st_q.req == '0 && !st_q.tx_full && st_q.released && !st_q.mst_irq); // R8

    AST_SEEN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.start_seen && st_q.stop_seen)); // R6

    AST_WRITE_LOADS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_write && !halt && !coll) |=> st_q.tx_full && st_q.ptr == PTR_LOAD); // R5

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ptr <= PTR_LOAD); // R5

    AST_IDLE_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && !tx_write) |=> !$rose(st_q.lost)); // R12

endmodule

// File: rtl/i2c_arb_guard.sv
module i2c_arb_guard #(
    parameter int NREQ        = 4,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2,
    localparam int PTR_W      = $clog2(DATA_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             mst_scl_rel,
    input  logic             mst_sda_rel,
    input  logic [NREQ-1:0]  req_set,
    input  logic [NREQ-1:0]  req_done,
    input  logic             tx_write,
    input  logic             tx_done,
    input  logic             sleep_req,
    input  logic             idle_req,
    input  logic             stop_in_idle,
    output logic             scl_out,
    output logic             sda_out,
    output logic [NREQ-1:0]  req_pend,
    output logic             tx_full,
    output logic [PTR_W-1:0] bit_ptr,
    output logic             arb_lost,
    output logic             start_seen,
    output logic             stop_seen,
    output logic             bus_free,
    output logic             mst_irq,
    output logic             evt_irq
);

    logic [2:0] raw_v;
    logic [2:0] syn_v;
    logic       scl_s, sda_s, rel_s;
    logic       scl_high, scl_fall, start_det, stop_det;
    logic       released;

    // The intent bit travels through the same chain as the lines so both stay aligned.
    assign raw_v = {mst_sda_rel, sda_in, scl_in};
    assign scl_s = syn_v[0];
    assign sda_s = syn_v[1];
    assign rel_s = syn_v[2];

    i2c_arb_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_v),
        .d_out (syn_v)
    );

    i2c_arb_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_high  (scl_high),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_arb_core #(
        .NREQ      (NREQ),
        .DATA_BITS (DATA_BITS)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_high     (scl_high),
        .scl_fall     (scl_fall),
        .sda_s        (sda_s),
        .rel_s        (rel_s),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .req_set      (req_set),
        .req_done     (req_done),
        .tx_write     (tx_write),
        .tx_done      (tx_done),
        .sleep_req    (sleep_req),
        .idle_req     (idle_req),
        .stop_in_idle (stop_in_idle),
        .release_o    (released),
        .req_o        (req_pend),
        .tx_full_o    (tx_full),
        .ptr_o        (bit_ptr),
        .lost_o       (arb_lost),
        .start_seen_o (start_seen),
        .stop_seen_o  (stop_seen),
        .bus_free_o   (bus_free),
        .mst_irq_o    (mst_irq),
        .evt_irq_o    (evt_irq)
    );

    assign sda_out = mst_sda_rel | released;
    assign scl_out = mst_scl_rel | released;

endmodule

// File: tb/test_i2c_arb_guard.sv
`timescale 1ns/1ps
module test_i2c_arb_guard;

    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic scl_drv = 1'b1, tb_sda = 1'b1;
    logic a_rel = 1'b1, b_rel = 1'b1;
    logic [3:0] a_rset = '0, a_rdone = '0, b_rset = '0, b_rdone = '0;
    logic a_wr = 0, a_done = 0, b_wr = 0, b_done = 0;
    logic a_sleep = 0, a_idle = 0, a_sidl = 0;

    logic a_scl_o, a_sda_o, b_scl_o, b_sda_o;
    logic [3:0] a_req, b_req;
    logic a_full, b_full, a_lost, b_lost;
    logic [3:0] a_ptr, b_ptr;
    logic a_ss, a_ps, a_free, a_mirq, a_eirq;
    logic b_ss, b_ps, b_free, b_mirq, b_eirq;
    logic sda_bus, scl_bus;

    assign sda_bus = a_sda_o & b_sda_o & tb_sda;
    assign scl_bus = a_scl_o & b_scl_o;

    i2c_arb_guard i_i2c_arb_guard (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .mst_scl_rel(scl_drv), .mst_sda_rel(a_rel), .req_set(a_rset), .req_done(a_rdone),
        .tx_write(a_wr), .tx_done(a_done), .sleep_req(a_sleep), .idle_req(a_idle),
        .stop_in_idle(a_sidl), .scl_out(a_scl_o), .sda_out(a_sda_o), .req_pend(a_req),
        .tx_full(a_full), .bit_ptr(a_ptr), .arb_lost(a_lost), .start_seen(a_ss),
        .stop_seen(a_ps), .bus_free(a_free), .mst_irq(a_mirq), .evt_irq(a_eirq));

    i2c_arb_guard i_i2c_arb_guard_b (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .mst_scl_rel(scl_drv), .mst_sda_rel(b_rel), .req_set(b_rset), .req_done(b_rdone),
        .tx_write(b_wr), .tx_done(b_done), .sleep_req(1'b0), .idle_req(1'b0),
        .stop_in_idle(1'b0), .scl_out(b_scl_o), .sda_out(b_sda_o), .req_pend(b_req),
        .tx_full(b_full), .bit_ptr(b_ptr), .arb_lost(b_lost), .start_seen(b_ss),
        .stop_seen(b_ps), .bus_free(b_free), .mst_irq(b_mirq), .evt_irq(b_eirq));

    int n_chk = 0, n_err = 0;
    int a_mi = 0, b_mi = 0, a_ev = 0, b_ev = 0;
    bit finished = 0;

    always @(negedge clk) begin
        if (a_mirq) a_mi++;
        if (b_mirq) b_mi++;
        if (a_eirq) a_ev++;
        if (b_eirq) b_ev++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_pair(input logic [7:0] va, input logic [7:0] vb);
        int kd = -1;
        int ma0, mb0, ea0, eb0;
        logic [7:0] obs = '0;
        logic [7:0] expv;
        bit al, bl;
        for (int k = 7; k >= 0; k--) if (kd < 0 && va[k] != vb[k]) kd = k;
        al = (va > vb);
        bl = (vb > va);
        expv = (va < vb) ? va : vb;
        ma0 = a_mi; mb0 = b_mi; ea0 = a_ev; eb0 = b_ev;
        a_wr = 1; b_wr = 1; tick(1); a_wr = 0; b_wr = 0; tick(2);
        chk("R5 load ptr A", a_ptr, 8);
        a_rel = 0; b_rel = 0; tick(H);
        scl_drv = 0; tick(H);
        for (int k = 7; k >= 0; k--) begin
            a_rel = va[k]; b_rel = vb[k]; tick(H);
            scl_drv = 1; tick(H);
            obs[k] = sda_bus;
            scl_drv = 0; tick(H);
        end
        chk("R10 bus byte is lower value", obs, expv);
        chk("R1 A lost flag", a_lost, al);
        chk("R1 B lost flag", b_lost, bl);
        chk("R1 A irq count", a_mi - ma0, al);
        chk("R1 B irq count", b_mi - mb0, bl);
        chk("R2 A tx_full", a_full, !al);
        chk("R2 B tx_full", b_full, !bl);
        if (al) chk("R5 A ptr frozen at lost bit", a_ptr, kd);
        if (bl) chk("R5 B ptr frozen at lost bit", b_ptr, kd);
        if (!al && !bl) chk("R10 equal bytes no loss", a_lost | b_lost, 0);
        a_rel = 0; b_rel = 0; tick(H);
        chk("R2 A sda released", a_sda_o, al);
        chk("R2 A scl released", a_scl_o, al);
        chk("R2 B sda released", b_sda_o, bl);
        chk("R10 B scl follows drive", b_scl_o, bl);
        scl_drv = 1; tick(H);
        a_rel = 1; b_rel = 1; tick(H);
        chk("R4 A irq after stop", a_mi - ma0, al ? 2 : 0);
        chk("R4 B irq after stop", b_mi - mb0, bl ? 2 : 0);
        chk("R6 A events", a_ev - ea0, 2);
        chk("R6 B events", b_ev - eb0, 2);
        chk("R6 A stop_seen", {a_ss, a_ps}, 1);
        chk("R7 B bus_free", b_free, 1);
        a_done = 1; b_done = 1; tick(1); a_done = 0; b_done = 0; tick(1);
        if (!al) chk("R5 A ptr saturates", a_ptr, 0);
        if (!bl) chk("R5 B ptr saturates", b_ptr, 0);
        if (al) begin
            a_wr = 1; tick(1); a_wr = 0; tick(1);
            chk("R5 A retry ptr reload", a_ptr, 8);
            chk("R5 A lost cleared by write", a_lost, 0);
            a_done = 1; tick(1); a_done = 0;
        end
        if (bl) begin
            b_wr = 1; tick(1); b_wr = 0; tick(1);
            chk("R5 B retry ptr reload", b_ptr, 8);
            chk("R5 B lost cleared by write", b_lost, 0);
            b_done = 1; tick(1); b_done = 0;
        end
        tick(2);
    endtask

    initial begin
        int ma0, mb0, ea0;
        tick(3);
        rst_n = 1;
        tick(2);
        chk("R11 reset req", a_req, 0);
        chk("R11 reset tx_full", a_full, 0);
        chk("R11 reset ptr", a_ptr, 0);
        chk("R11 reset lost", a_lost, 0);
        chk("R11 reset seen bits", {a_ss, a_ps}, 0);
        chk("R7 reset bus_free", a_free, 1);
        chk("R11 reset lines follow", {a_sda_o, a_scl_o}, 3);

        for (int i = 0; i < 16; i++) begin
            logic [7:0] v;
            v = 8'((i * 37 + 5) & 255);
            run_pair(v, v ^ 8'(1 << (i % 8)));
        end
        run_pair(8'h5A, 8'h5A);

        // Start collision with Start and Ack pending; B idle watches
        ma0 = a_mi; mb0 = b_mi; ea0 = b_ev;
        a_rset = 4'b1001; tick(1); a_rset = '0; tick(2);
        chk("R3 requests pending", a_req, 9);
        tb_sda = 0; tick(H);
        chk("R3 requests cleared", a_req, 0);
        chk("R1 start collision lost", a_lost, 1);
        chk("R1 start collision irq", a_mi - ma0, 1);
        chk("R12 idle B no loss", b_lost, 0);
        chk("R6 B start seen", {b_ss, b_ps}, 2);
        chk("R7 bus busy", b_free, 0);
        a_rel = 0; tick(2);
        chk("R2 A sda released after loss", a_sda_o, 1);
        a_rel = 1;
        tb_sda = 1; tick(H);
        chk("R4 stop re-raises irq", a_mi - ma0, 2);
        chk("R4 no irq without loss", b_mi - mb0, 0);
        chk("R6 B two events", b_ev - ea0, 2);
        a_rdone = 4'hF; tick(1); a_rdone = 0;

        // Sleep abort
        ma0 = a_mi;
        a_wr = 1; a_rset = 4'b0100; tick(1); a_wr = 0; a_rset = '0; tick(1);
        a_sleep = 1; tick(1); a_sleep = 0; tick(2);
        chk("R8 sleep clears req", a_req, 0);
        chk("R8 sleep clears tx_full", a_full, 0);
        chk("R8 sleep no irq", a_mi - ma0, 0);
        scl_drv = 0; a_rel = 0; tick(2);
        chk("R8 sleep releases lines", {a_sda_o, a_scl_o}, 3);
        a_rel = 1; scl_drv = 1; tick(H);

        // Idle without and with stop-in-idle
        a_wr = 1; a_rset = 4'b0010; tick(1); a_wr = 0; a_rset = '0; tick(1);
        scl_drv = 0; tick(H);
        a_sidl = 0; a_idle = 1; tick(4);
        chk("R9 idle ignored req", a_req, 2);
        chk("R9 idle ignored tx_full", a_full, 1);
        a_rel = 0; tick(1);
        chk("R9 idle ignored lines", a_sda_o, 0);
        a_rel = 1; a_idle = 0; tick(1);
        a_sidl = 1; a_idle = 1; tick(3);
        chk("R9 stop-in-idle clears req", a_req, 0);
        chk("R9 stop-in-idle clears tx_full", a_full, 0);
        a_rel = 0; tick(1);
        chk("R9 stop-in-idle releases", a_sda_o, 1);
        a_rel = 1; a_idle = 0; a_sidl = 0; tick(1);
        scl_drv = 1; tick(H);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule